// File: doc/BRIEF.md
# Zoned External Memory Bus Controller

This block connects an internal request port, which carries one access at a time, to an off-chip asynchronous memory bus. That bus has a 19-bit address and a 16-bit data path. The zone number of a request picks a timing profile and an external chip select. Zones 0 and 1 share one select. Zones 6 and 7 share another. Zone 2 has a select of its own. Zones 3 to 5 run their cycle with every select left high.

Every access is built from three phases: setup (lead), strobe (active) and hold-off (trail). Each zone has its own cycle count for each phase. During the strobe phase a ready input from the device can stretch the cycle. That input can be used directly or passed through a two-flop synchronizer first. An outside master can take the bus with an active-low hold request. The controller first completes the access in flight, then releases every bus output and signals acknowledge. A free-running clock output, divided from the system clock, is also provided for external wait-state logic.

Pad drivers are outside the block. The block reports bus ownership on enable outputs and does not drive high impedance itself.

Top module: `xbus_ctrl`

## Requirements
- R1: `req_ready` is high only in the idle state while `hold_req_n` is high. An accepted access ends with a one-cycle `rsp_done` pulse in the cycle after its last bus cycle. For a read, `rsp_rdata` then holds the `bus_din` value present at the end of the strobe phase.
- R2: `rd_n` and `we_n` are never low together. `rd_n` is low only during the strobe phase of a read, and `we_n` only during the strobe phase of a write.
- R3: `rnw` is low for every cycle of a write access, from setup through hold-off. It is high at all other times.
- R4: Chip selects `{cs67_n,cs2_n,cs01_n}` are low for the whole access as follows: zones 0 and 1 give 3'b110, zone 2 gives 3'b101, zones 6 and 7 give 3'b011, and zones 3 to 5 give 3'b111. All selects are high outside an access.
- R5: For zone z, the 4-bit counts sit at bits [4z+3:4z] of `cfg_lead`, `cfg_act` and `cfg_trail`. Setup lasts max(1,L) cycles, strobe lasts max(1,A) cycles and hold-off lasts T cycles. A count of 0 for setup or strobe is therefore stretched to 1.
- R6: `bus_rdy` is sampled in the last strobe cycle, and while it reads low the strobe phase repeats. With `cfg_rdy_async`=1 the sampled value lags the pin by two extra cycles.
- R7: While `hold_req_n` is low, an access in flight runs to completion. The controller then enters the granted state: `hold_ack_n`=0, `bus_oe`=0, `dout_oe`=0 and no new request is accepted. In idle, a hold request takes priority over a waiting request.
- R8: After `hold_req_n` returns high, `hold_ack_n` and `bus_oe` go high on the next clock edge, and requests are accepted again.
- R9: `clk_out` follows `cfg_clk_div`: 2'b00 and 2'b11 give clk/4, 2'b01 gives clk/2 and 2'b10 gives clk itself. An all-zero setting therefore means divide-by-4. `cfg_clk_off`=1 forces `clk_out` low.
- R10: During an access, `bus_addr` carries the request address. During a write, `dout_oe`=1 and `bus_dout` carries the write data for every cycle of the access. `dout_oe` is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | 3 | Target zone |
| req_addr | input | 19 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | Access complete pulse |
| cfg_lead | input | 32 | Setup counts, 4 bits per zone |
| cfg_act | input | 32 | Strobe counts, 4 bits per zone |
| cfg_trail | input | 32 | Hold-off counts, 4 bits per zone |
| cfg_rdy_async | input | 1 | Synchronize bus_rdy before use |
| cfg_clk_div | input | 2 | Clock output divider select |
| cfg_clk_off | input | 1 | Force clock output low |
| hold_req_n | input | 1 | External master bus request, active low |
| hold_ack_n | output | 1 | Bus granted, active low |
| bus_oe | output | 1 | Address, selects and strobes are driven |
| bus_addr | output | 19 | External address |
| cs01_n | output | 1 | Select for zones 0 and 1 |
| cs2_n | output | 1 | Select for zone 2 |
| cs67_n | output | 1 | Select for zones 6 and 7 |
| rd_n | output | 1 | Read strobe |
| we_n | output | 1 | Write strobe |
| rnw | output | 1 | Read-not-write indicator |
| bus_dout | output | 16 | Data to drive on the bus |
| dout_oe | output | 1 | Data output enable |
| bus_din | input | 16 | Data read from the bus |
| bus_rdy | input | 1 | Device ready |
| clk_out | output | 1 | Divided clock output |

## Verification
Timing is counted from the clock edge that accepts a request. Setup occupies the next max(1,L) cycles, strobe the following max(1,A) cycles plus any ready stretch, and hold-off the next T cycles. `rsp_done` is high in the cycle after that.

The bench samples every output at the falling edge, a half cycle after the edge that updates it. It counts phase lengths cycle by cycle rather than waiting a fixed delay, and it sweeps every combination of L, A and T from 0 to 3.

A ready release is due in the same cycle in synchronous mode and two cycles later in asynchronous mode. A hold grant appears one cycle after the completion pulse when an access was in flight, and one cycle after the request when the bus was idle. Bus ownership returns one cycle after the request is withdrawn.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_TRAIL,
    ST_HOLD
  } xb_state_t;
endpackage

// File: rtl/xbus_phase_sel.sv
module xbus_phase_sel #(
  parameter int NZ = 8,
  parameter int CW = 4,
  localparam int ZW = $clog2(NZ)
) (
  input  logic [NZ*CW-1:0] cfg_lead,
  input  logic [NZ*CW-1:0] cfg_act,
  input  logic [NZ*CW-1:0] cfg_trail,
  input  logic [ZW-1:0]    zone,
  output logic [CW-1:0]    lead_m1,
  output logic [CW-1:0]    act_m1,
  output logic [CW-1:0]    trail_raw
);
  logic [CW-1:0] lead_raw, act_raw;

  always_comb begin
    lead_raw  = cfg_lead[zone*CW +: CW];
    act_raw   = cfg_act[zone*CW +: CW];
    trail_raw = cfg_trail[zone*CW +: CW];
    // zero counts stretch to a single cycle
    lead_m1   = (lead_raw == '0) ? '0 : lead_raw - 1'b1;
    act_m1    = (act_raw == '0)  ? '0 : act_raw - 1'b1;
  end
endmodule

// File: rtl/xbus_zone_dec.sv
module xbus_zone_dec #(
  parameter int NZ = 8,
  localparam int ZW = $clog2(NZ)
) (
  input  logic [ZW-1:0] zone,
  input  logic          active,
  output logic [2:0]    sel_n
);
  logic [2:0] hit;

  // bit 0: zones 0/1, bit 1: zone 2, bit 2: zones 6/7
  always_comb begin
    hit = '0;
    for (int z = 0; z < NZ; z++) begin
      if (zone == ZW'(z)) begin
        if (z == 0 || z == 1) hit[0] = 1'b1;
        if (z == 2)           hit[1] = 1'b1;
        if (z == 6 || z == 7) hit[2] = 1'b1;
      end
    end
    sel_n = ~(hit & {3{active}});
  end
endmodule

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_pin,
  input  logic use_sync,
  output logic rdy_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], rdy_pin};
  end

  assign rdy_out = use_sync ? sync_q[STAGES-1] : rdy_pin;
endmodule

// File: rtl/xbus_clkdiv.sv
module xbus_clkdiv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       off,
  output logic       clk_out
);
  logic [1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (off)                  clk_out = 1'b0;
    else if (div_sel == 2'b10) clk_out = clk;
    else if (div_sel == 2'b01) clk_out = cnt_q[0];
    else                       clk_out = cnt_q[1];
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16,
  parameter int NZ = 8,
  parameter int CW = 4,
  localparam int ZW = $clog2(NZ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [ZW-1:0] req_zone,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  input  logic [NZ*CW-1:0] cfg_lead,
  input  logic [NZ*CW-1:0] cfg_act,
  input  logic [NZ*CW-1:0] cfg_trail,
  input  logic          cfg_rdy_async,
  input  logic [1:0]    cfg_clk_div,
  input  logic          cfg_clk_off,
  input  logic          hold_req_n,
  output logic          hold_ack_n,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          cs01_n,
  output logic          cs2_n,
  output logic          cs67_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          rnw,
  output logic [DW-1:0] bus_dout,
  output logic          dout_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_rdy,
  output logic          clk_out
);
  xb_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [ZW-1:0] zone_q, sel_zone;
  logic          wr_q, acc_ld, rdata_ld, in_acc, rdy_s;
  logic [CW-1:0] lead_m1, act_m1, trail_raw;
  logic [2:0]    sel_n;

  assign sel_zone = (st_q == ST_IDLE) ? req_zone : zone_q;

  xbus_phase_sel #(.NZ(NZ), .CW(CW)) u_phase (
    .cfg_lead(cfg_lead), .cfg_act(cfg_act), .cfg_trail(cfg_trail),
    .zone(sel_zone), .lead_m1(lead_m1), .act_m1(act_m1), .trail_raw(trail_raw)
  );

  xbus_rdy_sync #(.STAGES(2)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rdy_pin(bus_rdy),
    .use_sync(cfg_rdy_async), .rdy_out(rdy_s)
  );

  xbus_clkdiv u_clk (
    .clk(clk), .rst_n(rst_n), .div_sel(cfg_clk_div),
    .off(cfg_clk_off), .clk_out(clk_out)
  );

  assign in_acc = (st_q == ST_LEAD) || (st_q == ST_ACT) || (st_q == ST_TRAIL);

  xbus_zone_dec #(.NZ(NZ)) u_dec (
    .zone(zone_q), .active(in_acc), .sel_n(sel_n)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    acc_ld   = 1'b0;
    rdata_ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!hold_req_n) begin
          st_d = ST_HOLD;
        end else if (req_valid) begin
          acc_ld = 1'b1;
          st_d   = ST_LEAD;
          cnt_d  = lead_m1;
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          st_d  = ST_ACT;
          cnt_d = act_m1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (rdy_s) begin
          rdata_ld = !wr_q;
          if (trail_raw == '0) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d  = ST_TRAIL;
            cnt_d = trail_raw - 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_req_n) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // request capture with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      zone_q  <= '0;
      wr_q    <= 1'b0;
    end else if (acc_ld) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      zone_q  <= req_zone;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_ld) rdata_q <= bus_din;
  end

  // outputs
  assign req_ready  = (st_q == ST_IDLE) && hold_req_n;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign hold_ack_n = (st_q != ST_HOLD);
  assign bus_oe     = (st_q != ST_HOLD);
  assign bus_addr   = addr_q;
  assign {cs67_n, cs2_n, cs01_n} = sel_n;
  assign rd_n       = !((st_q == ST_ACT) && !wr_q);
  assign we_n       = !((st_q == ST_ACT) && wr_q);
  assign rnw        = !(in_acc && wr_q);
  assign bus_dout   = wdata_q;
  assign dout_oe    = in_acc && wr_q;

  // assertions
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !we_n));
  a_r3_read_keeps_rnw: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> rnw);
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~cs67_n, ~cs2_n, ~cs01_n}));
  a_r5_no_strobe_in_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD) |-> (rd_n && we_n));
  a_r6_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && cnt_q == '0 && !rdy_s) |=> (st_q == ST_ACT));
  a_r7_granted_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (!bus_oe && !dout_oe && !req_ready));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack_n && hold_req_n) |=> hold_ack_n);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  localparam int NZ = 8;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [2:0]  req_zone;
  logic [18:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata;
  logic        rsp_done;
  logic [NZ*CW-1:0] cfg_lead, cfg_act, cfg_trail;
  logic        cfg_rdy_async, cfg_clk_off;
  logic [1:0]  cfg_clk_div;
  logic        hold_req_n, hold_ack_n, bus_oe;
  logic [18:0] bus_addr;
  logic        cs01_n, cs2_n, cs67_n, rd_n, we_n, rnw, dout_oe, bus_rdy, clk_out;
  logic [15:0] bus_dout, bus_din;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_zone(req_zone), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .cfg_lead(cfg_lead), .cfg_act(cfg_act), .cfg_trail(cfg_trail),
    .cfg_rdy_async(cfg_rdy_async), .cfg_clk_div(cfg_clk_div),
    .cfg_clk_off(cfg_clk_off), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
    .bus_oe(bus_oe), .bus_addr(bus_addr), .cs01_n(cs01_n), .cs2_n(cs2_n),
    .cs67_n(cs67_n), .rd_n(rd_n), .we_n(we_n), .rnw(rnw), .bus_dout(bus_dout),
    .dout_oe(dout_oe), .bus_din(bus_din), .bus_rdy(bus_rdy), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sel(input logic [2:0] z);
    case (z)
      3'd0, 3'd1: return 3'b110;
      3'd2:       return 3'b101;
      3'd6, 3'd7: return 3'b011;
      default:    return 3'b111;
    endcase
  endfunction

  // runs one access; counts phases; rel>0 releases bus_rdy after rel strobe cycles
  task automatic run_acc(input logic [2:0] z, input bit wr, input logic [18:0] a,
                         input logic [15:0] wd, input int el, input int ea, input int et,
                         input int rel, input bit hold_mid);
    int nl = 0, na = 0, nt = 0, guard = 0;
    bit seen = 0, ok_sel = 1, ok_rw = 1, ok_dat = 1, ok_hold = 1;
    logic [15:0] din_v;
    din_v = a[15:0] ^ 16'h5A5A;
    bus_din   = din_v;
    req_zone  = z;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready in idle", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && guard < 200) begin
      guard++;
      if ({cs67_n, cs2_n, cs01_n} !== exp_sel(z)) ok_sel = 0;
      if (rnw !== !wr || dout_oe !== wr) ok_rw = 0;
      if (bus_addr !== a || (wr && bus_dout !== wd)) ok_dat = 0;
      if (hold_ack_n !== 1'b1) ok_hold = 0;
      if (hold_mid) hold_req_n = 1'b0;
      if ((wr ? we_n : rd_n) == 1'b0) begin
        na++;
        seen = 1;
        if ((wr ? rd_n : we_n) != 1'b1) ok_rw = 0;
        if (rel > 0 && na == rel) bus_rdy = 1'b1;
      end else if (!seen) begin
        nl++;
      end else begin
        nt++;
      end
      @(negedge clk);
    end
    chk(nl == el, "R5 setup length", nl, el);
    chk(na == ea, "R5/R6 strobe length", na, ea);
    chk(nt == et, "R5 hold-off length", nt, et);
    chk(ok_sel, "R4 zone select", int'({cs67_n, cs2_n, cs01_n}), int'(exp_sel(z)));
    chk(ok_rw, "R2/R3 strobe and rnw", int'(rnw), int'(!wr));
    chk(ok_dat, "R10 address and data", int'(bus_addr), int'(a));
    chk({cs67_n, cs2_n, cs01_n, rnw, rd_n, we_n} == 6'h3F, "R4 idle after access",
        int'({cs67_n, cs2_n, cs01_n}), 7);
    if (hold_mid) chk(ok_hold, "R7 access completes before grant", 0, 1);
    if (!wr) chk(rsp_rdata == din_v, "R1 read data", int'(rsp_rdata), int'(din_v));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R1 done is one pulse", int'(rsp_done), 0);
  endtask

  task automatic set_zone(input int z, input int l, input int a, input int t);
    cfg_lead[z*CW +: CW]  = CW'(l);
    cfg_act[z*CW +: CW]   = CW'(a);
    cfg_trail[z*CW +: CW] = CW'(t);
  endtask

  task automatic clk_toggles(input logic [1:0] d, input bit off, input int exp);
    int tg = 0;
    bit any_hi = 0;
    logic prev;
    cfg_clk_div = d;
    cfg_clk_off = off;
    @(negedge clk);
    @(negedge clk);
    prev = clk_out;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (clk_out != prev) tg++;
      if (clk_out) any_hi = 1;
      prev = clk_out;
    end
    chk(tg == exp && !(off && any_hi), "R9 clock output toggles", tg, exp);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_zone = 0; req_addr = 0; req_wdata = 0;
    cfg_lead = '0; cfg_act = '0; cfg_trail = '0;
    cfg_rdy_async = 0; cfg_clk_div = 2'b00; cfg_clk_off = 0;
    hold_req_n = 1; bus_din = 0; bus_rdy = 1;
    repeat (3) @(negedge clk);
    chk({hold_ack_n, bus_oe, rd_n, we_n, rnw, cs01_n, cs2_n, cs67_n, rsp_done} == 9'h1FE,
        "R1 reset state", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 sweep of every phase combination, rotating zones and direction
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < 4; a++)
        for (int t = 0; t < 4; t++) begin
          int k = l * 16 + a * 4 + t;
          logic [2:0] z = 3'(k % 8);
          set_zone(int'(z), l, a, t);
          run_acc(z, k[0], 19'(k * 4099 + 7), 16'(k * 331 + 1),
                  (l == 0) ? 1 : l, (a == 0) ? 1 : a, t, 0, 0);
        end

    // R6 ready stretch, synchronous then asynchronous
    set_zone(2, 1, 1, 1);
    bus_rdy = 1'b0;
    run_acc(3'd2, 0, 19'h12345, 16'h0, 1, 5, 1, 5, 0);
    cfg_rdy_async = 1'b1;
    bus_rdy = 1'b0;
    repeat (3) @(negedge clk);
    run_acc(3'd2, 1, 19'h54321, 16'hBEEF, 1, 7, 1, 5, 0);
    cfg_rdy_async = 1'b0;

    // R7 hold raised mid-access: access finishes, grant one cycle after done
    set_zone(6, 2, 2, 2);
    run_acc(3'd6, 1, 19'h00ABC, 16'hCAFE, 2, 2, 2, 0, 1);
    chk(hold_ack_n == 1'b0 && bus_oe == 1'b0 && dout_oe == 1'b0, "R7 granted after access",
        int'(hold_ack_n), 0);
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R7 no accept while granted", int'(req_ready), 0);
    @(negedge clk);
    chk({cs67_n, cs2_n, cs01_n} == 3'b111 && hold_ack_n == 1'b0, "R7 request stalled",
        int'({cs67_n, cs2_n, cs01_n}), 7);
    req_valid = 1'b0;
    hold_req_n = 1'b1;
    @(negedge clk);
    chk(hold_ack_n == 1'b1 && bus_oe == 1'b1, "R8 bus returned", int'(hold_ack_n), 1);
    #1;
    chk(req_ready == 1'b1, "R8 accepting again", int'(req_ready), 1);
    @(negedge clk);

    // R7 hold in idle wins over a waiting request
    hold_req_n = 1'b0;
    req_valid  = 1'b1;
    req_zone   = 3'd0;
    @(negedge clk);
    chk(hold_ack_n == 1'b0 && cs01_n == 1'b1, "R7 hold priority in idle", int'(hold_ack_n), 0);
    req_valid  = 1'b0;
    hold_req_n = 1'b1;
    @(negedge clk);
    chk(hold_ack_n == 1'b1, "R8 release from idle grant", int'(hold_ack_n), 1);

    // R9 clock output
    clk_toggles(2'b00, 0, 4);
    clk_toggles(2'b11, 0, 4);
    clk_toggles(2'b01, 0, 8);
    clk_toggles(2'b01, 1, 0);
    cfg_clk_off = 0;
    cfg_clk_div = 2'b10;
    @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R9 undivided high phase", int'(clk_out), 1);
    @(negedge clk);
    #1;
    chk(clk_out == 1'b0, "R9 undivided low phase", int'(clk_out), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule